// File: doc/BRIEF.md
# Prefix-Parity Checksum Codec

This block guards a data byte with an equal-width checksum and can repair a single flipped data bit. Checksum bit i is the even parity of data bits i down to 0. Bit 0 therefore equals the data LSB, and the top checksum bit covers the whole byte. The encoder side is serial. A shift register is cleared, then the byte is fed through it LSB first in two passes, for 2×DATA_W shifts in total. At the end the register holds the byte in its upper half and the checksum in its lower half, and this protected word is presented in parallel.

The decoder side takes a received protected word and treats its checksum field as correct. It recomputes the checksum of the received data. When the two differ, it evaluates DATA_W hypotheses in parallel, each with exactly one data bit inverted, and adopts the hypothesis whose checksum equals the received one. The result is registered and appears one cycle after the word is presented.

Stream rules:
- Encoder input: a valid/ready pair. `enc_in_ready` is low for the whole conversion, and a byte transfers only in a cycle where valid and ready are both high.
- Encoder output: no back-pressure. `enc_done` pulses once and `enc_word` then stays constant until the next byte is accepted.
- Decoder input: always ready, so it accepts a word in every cycle that `dec_in_valid` is high.
- Decoder output: a single-cycle `dec_out_valid` pulse with no back-pressure.

Top module: `cpar_codec`

## Requirements
- R1: After reset `enc_busy`, `enc_done`, `dec_out_valid`, `dec_out_fixed` and `dec_out_bad` are 0, `enc_in_ready` is 1 and `enc_word` is 0.
- R2: A byte is accepted on a clock edge where `enc_in_valid` and `enc_in_ready` are both 1. `enc_busy` is then 1 (and `enc_in_ready` 0) for exactly 16 cycles (2×DATA_W). After that, `enc_done` is 1 for exactly one cycle, in which `enc_busy` is already 0.
- R3: When `enc_done` is 1, `enc_word[15:8]` is the accepted byte and `enc_word[i]` for i in 0..7 is the XOR of data bits i..0. For example, 8'hAB encodes to 16'hAB99.
- R4: `enc_word` does not change from the end of a conversion until the next accepted byte. An `enc_in_valid` pulse while busy is ignored, so the finished word belongs to the first byte.
- R5: `dec_out_valid` is 1 exactly in the cycle after a cycle with `dec_in_valid` = 1.
- R6: A received word whose checksum field `[7:0]` matches the recomputed checksum of `[15:8]` gives `dec_out_data` equal to the received data, with `dec_out_fixed` = 0 and `dec_out_bad` = 0.
- R7: When exactly one single-bit data inversion makes the checksums agree, `dec_out_data` is the inverted byte and `dec_out_fixed` = 1. For example, 16'hAA99 gives 8'hAB.
- R8: When no single-bit inversion makes the checksums agree, `dec_out_data` is the received data unchanged, `dec_out_bad` = 1 and `dec_out_fixed` = 0. For example, 16'h2A99 gives 8'h2A and bad.
- R9: `dec_out_fixed` and `dec_out_bad` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Byte offered to encoder |
| enc_in_ready | output | 1 | Encoder can take a byte |
| enc_in_data | input | DATA_W | Byte to protect |
| enc_busy | output | 1 | Conversion in progress |
| enc_done | output | 1 | One-cycle pulse, protected word ready |
| enc_word | output | 2×DATA_W | Protected word: data high, checksum low |
| dec_in_valid | input | 1 | Received word present |
| dec_in_word | input | 2×DATA_W | Received protected word |
| dec_out_valid | output | 1 | Decoder result valid pulse |
| dec_out_data | output | DATA_W | Repaired or passed-through data |
| dec_out_fixed | output | 1 | A single data bit was repaired |
| dec_out_bad | output | 1 | No single-bit repair matched |

## Verification
A wrong shift count or feedback tap in the encoder leaves the done pulse either early or late against the 17-cycle frame. Otherwise it leaves a wrongly encoded lower byte, visible at the port in the same cycle that `enc_done` rises. A hypothesis that is wrongly built or wrongly selected in the decoder shows one cycle after the input word, as wrong data or wrong flags. Vectors with every data bit position inverted, and one with two inversions, expose each hypothesis lane separately.

// File: rtl/cpar_pkg.sv
package cpar_pkg;
  localparam int unsigned CP_DATA_W = 8;

  typedef enum logic [1:0] {
    VERDICT_CLEAN = 2'd0,
    VERDICT_FIXED = 2'd1,
    VERDICT_BAD   = 2'd2
  } verdict_e;
endpackage

// File: rtl/cpar_sum.sv
module cpar_sum #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] sum
);
  // running parity from the LSB upward
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      acc    = acc ^ data[i];
      sum[i] = acc;
    end
  end
endmodule

// File: rtl/cpar_serial_enc.sv
module cpar_serial_enc #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DATA_W-1:0]     data,
  output logic                  busy,
  output logic                  done,
  output logic [2*DATA_W-1:0]   word
);
  localparam int unsigned WORD_W = 2 * DATA_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr, sr_nxt;
  logic [DATA_W-1:0] src;
  logic [CNT_W-1:0]  cnt;

  // serial input enters at the top, one feedback cell at the half boundary
  always_comb begin
    sr_nxt[WORD_W-1] = src[0];
    for (int i = DATA_W; i < WORD_W - 1; i++) sr_nxt[i] = sr[i+1];
    sr_nxt[DATA_W-1] = sr[DATA_W] ^ sr[DATA_W-1];
    for (int i = 0; i < DATA_W - 1; i++) sr_nxt[i] = sr[i+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      src  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sr   <= '0;
        src  <= data;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        sr  <= sr_nxt;
        src <= {src[0], src[DATA_W-1:1]};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign word = sr;
endmodule

// File: rtl/cpar_hyp_dec.sv
module cpar_hyp_dec
  import cpar_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*DATA_W-1:0] in_word,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_fixed,
  output logic                out_bad
);
  logic [DATA_W-1:0] rx_data, rx_sum, base_sum;
  logic [DATA_W-1:0] hyp_data [DATA_W];
  logic [DATA_W-1:0] hyp_sum  [DATA_W];
  logic [DATA_W-1:0] hit;
  logic [DATA_W-1:0] pick_data;
  verdict_e          verdict;

  assign rx_data = in_word[2*DATA_W-1:DATA_W];
  assign rx_sum  = in_word[DATA_W-1:0];

  cpar_sum #(.DATA_W(DATA_W)) u_base (.data(rx_data), .sum(base_sum));

  for (genvar h = 0; h < DATA_W; h++) begin : g_hyp
    assign hyp_data[h] = rx_data ^ (DATA_W'(1) << h);
    cpar_sum #(.DATA_W(DATA_W)) u_sum (.data(hyp_data[h]), .sum(hyp_sum[h]));
    assign hit[h] = (hyp_sum[h] == rx_sum);
  end

  always_comb begin
    pick_data = rx_data;
    verdict   = VERDICT_BAD;
    if (base_sum == rx_sum) begin
      verdict = VERDICT_CLEAN;
    end else begin
      for (int h = DATA_W - 1; h >= 0; h--) begin
        if (hit[h]) begin
          pick_data = hyp_data[h];
          verdict   = VERDICT_FIXED;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fixed <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= pick_data;
        out_fixed <= (verdict == VERDICT_FIXED);
        out_bad   <= (verdict == VERDICT_BAD);
      end
    end
  end
endmodule

// File: rtl/cpar_codec.sv
module cpar_codec
  import cpar_pkg::*;
#(
  parameter int unsigned DATA_W = CP_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_in_valid,
  output logic                enc_in_ready,
  input  logic [DATA_W-1:0]   enc_in_data,
  output logic                enc_busy,
  output logic                enc_done,
  output logic [2*DATA_W-1:0] enc_word,
  input  logic                dec_in_valid,
  input  logic [2*DATA_W-1:0] dec_in_word,
  output logic                dec_out_valid,
  output logic [DATA_W-1:0]   dec_out_data,
  output logic                dec_out_fixed,
  output logic                dec_out_bad
);
  cpar_serial_enc #(.DATA_W(DATA_W)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (enc_in_valid),
    .data  (enc_in_data),
    .busy  (enc_busy),
    .done  (enc_done),
    .word  (enc_word)
  );

  assign enc_in_ready = !enc_busy;

  cpar_hyp_dec #(.DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_word   (dec_in_word),
    .out_valid (dec_out_valid),
    .out_data  (dec_out_data),
    .out_fixed (dec_out_fixed),
    .out_bad   (dec_out_bad)
  );
endmodule

// File: rtl/cpar_codec_chk.sv
module cpar_codec_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enc_in_valid,
  input logic                enc_in_ready,
  input logic                enc_busy,
  input logic                enc_done,
  input logic [2*DATA_W-1:0] enc_word,
  input logic                dec_in_valid,
  input logic [2*DATA_W-1:0] dec_in_word,
  input logic                dec_out_valid,
  input logic [DATA_W-1:0]   dec_out_data,
  input logic                dec_out_fixed,
  input logic                dec_out_bad
);
  logic [DATA_W-1:0] enc_ref, dec_ref;

  always_comb begin
    logic a, b;
    a = 1'b0;
    b = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      a = a ^ enc_word[DATA_W+i];
      b = b ^ dec_out_data[i];
      enc_ref[i] = a;
      dec_ref[i] = b;
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |-> !enc_busy);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |-> $past(enc_busy));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_in_valid && enc_in_ready) |=> enc_busy);
  // R3
  enc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |-> (enc_word[DATA_W-1:0] == enc_ref));
  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_busy && !enc_in_valid) |=> $stable(enc_word));
  // R5
  dec_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid |=> dec_out_valid);
  // R5
  dec_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> $past(dec_in_valid));
  // R7
  dec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && !dec_out_bad) |-> (dec_ref == $past(dec_in_word[DATA_W-1:0])));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_out_fixed && dec_out_bad));
endmodule

bind cpar_codec cpar_codec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cpar_codec_bench.sv
module cpar_codec_bench;
  localparam int DW = 8;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_in_valid = 1'b0;
  logic enc_in_ready;
  logic [DW-1:0] enc_in_data = '0;
  logic enc_busy, enc_done;
  logic [WW-1:0] enc_word;
  logic dec_in_valid = 1'b0;
  logic [WW-1:0] dec_in_word = '0;
  logic dec_out_valid;
  logic [DW-1:0] dec_out_data;
  logic dec_out_fixed, dec_out_bad;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cpar_codec u_cpar_codec (.*);

  // {received word, expected data, fixed, bad}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {16'hAB99, 8'hAB, 1'b0, 1'b0},
    {16'hAA99, 8'hAB, 1'b1, 1'b0},
    {16'h2B99, 8'hAB, 1'b1, 1'b0},
    {16'hAF99, 8'hAB, 1'b1, 1'b0},
    {16'h2A99, 8'h2A, 1'b0, 1'b1},
    {16'h0000, 8'h00, 1'b0, 1'b0},
    {16'hFF55, 8'hFF, 1'b0, 1'b0},
    {16'hFE55, 8'hFF, 1'b1, 1'b0},
    {16'h7F55, 8'hFF, 1'b1, 1'b0}
  };

  function automatic logic [DW-1:0] ref_sum(input logic [DW-1:0] d);
    logic [DW-1:0] s;
    for (int i = 0; i < DW; i++) begin
      int ones;
      ones = 0;
      for (int j = 0; j <= i; j++) ones += d[j];
      s[i] = ones[0];
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_dec(input logic [WW-1:0] w, input logic [DW-1:0] ed,
                         input logic ef, input logic eb);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_word  = w;
    @(negedge clk);
    dec_in_valid = 1'b0;
    check("R5 valid", 32'(dec_out_valid), 32'd1);
    check(eb ? "R8 data" : (ef ? "R7 data" : "R6 data"), 32'(dec_out_data), 32'(ed));
    check("R7 fixed", 32'(dec_out_fixed), 32'(ef));
    check("R8 bad", 32'(dec_out_bad), 32'(eb));
    check("R9 excl", 32'(dec_out_fixed & dec_out_bad), 32'd0);
    @(negedge clk);
    check("R5 pulse", 32'(dec_out_valid), 32'd0);
  endtask

  task automatic run_enc(input logic [DW-1:0] d, input logic poke);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_data  = d;
    @(negedge clk);
    enc_in_valid = 1'b0;
    for (int k = 1; k <= 17; k++) begin
      if (k > 1) @(negedge clk);
      if (poke && k == 5) begin
        enc_in_valid = 1'b1;
        enc_in_data  = ~d;
      end
      if (poke && k == 6) enc_in_valid = 1'b0;
      if (k <= 16) begin
        check("R2 busy", 32'(enc_busy), 32'd1);
        check("R2 ready", 32'(enc_in_ready), 32'd0);
        check("R2 nodone", 32'(enc_done), 32'd0);
      end else begin
        check("R2 done", 32'(enc_done), 32'd1);
        check("R2 idle", 32'(enc_busy), 32'd0);
        check(poke ? "R4 word" : "R3 word", 32'(enc_word), 32'({d, ref_sum(d)}));
      end
    end
    @(negedge clk);
    check("R2 done pulse", 32'(enc_done), 32'd0);
    repeat (3) @(negedge clk);
    check("R4 hold", 32'(enc_word), 32'({d, ref_sum(d)}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(enc_busy), 32'd0);
    check("R1 done", 32'(enc_done), 32'd0);
    check("R1 ready", 32'(enc_in_ready), 32'd1);
    check("R1 word", 32'(enc_word), 32'd0);
    check("R1 dvalid", 32'(dec_out_valid), 32'd0);
    check("R1 flags", 32'({dec_out_fixed, dec_out_bad}), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_dec(VEC[v][25:10], VEC[v][9:2], VEC[v][1], VEC[v][0]);

    // every data lane of a single-bit inversion
    for (int b = 0; b < DW; b++)
      run_dec({8'h5C ^ (8'd1 << b), ref_sum(8'h5C)}, 8'h5C, 1'b1, 1'b0);

    run_enc(8'hAB, 1'b0);
    check("R3 example", 32'(enc_word), 32'h0000AB99);
    run_enc(8'h00, 1'b0);
    run_enc(8'hFF, 1'b0);
    run_enc(8'h81, 1'b1);
    run_enc(8'h3C, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule